// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when the outputs of a differential clock fan-out buffer may drive. It runs on a free-running reference clock and steps through four numbered states. In **Off** (0) it waits for the supply-good indication. In **Settle** (1) it waits a fixed number of reference cycles so the supply can stabilise. In **Wait** (2) it waits for three things: a valid input clock, the power-good / power-down pin released high, and a lock report from the loop. Once all three hold it enters **Run** (3), and only in Run are the outputs enabled.

The control pin does two jobs. Its first rising edge after supply-good captures the strap inputs: a frequency select and two tri-level address straps. After that capture the same pin is read only as an active-low power-down. Losing the input clock, losing lock, or pulling the pin low moves the sequencer from Run back to Wait. Losing supply-good sends it to Off from any state and discards the captured straps.

The transitions are named as follows:
- **Power-on**: Off to Settle.
- **Settle-done**: Settle to Wait.
- **Qualify**: Wait to Run.
- **Fall-back**: Run to Wait.
- **Supply-loss**: any state to Off.

The settle delay is the parameter `DELAY_CYCLES`. Its default of 25000 cycles gives 0.1 ms at a 250 MHz reference clock. That default sits at the low end of the allowed 0.1 ms to 0.3 ms window, which keeps the total power-up time well under 1.8 ms.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (Off), `out_en` is 0 and `cfg_valid` is 0.
- R2: In Off, `supply_ok` high at a clock edge moves the state to 1 (Settle) at that edge.
- R3: Settle lasts exactly `DELAY_CYCLES` clock cycles and then moves to 2 (Wait).
- R4: Wait moves to 3 (Run) at the first edge where all of these hold:
  - `clk_valid` is high;
  - `pll_lock` is high;
  - `cfg_valid` is high;
  - `pgood_pdn_n`, seen through a two-stage synchroniser, is high.
- R5: While `clk_valid` is low, the state never becomes Run and `out_en` stays 0, even when the pin and lock are both high.
- R6: In Run, `clk_valid` low or `pll_lock` low returns the state to Wait at the next edge. The synchronised pin low does the same, which takes effect three edges after the pin falls.
- R7: `supply_ok` low returns the state to Off at the next edge from any state, and clears `cfg_valid` and all captured fields to 0.
- R8: The first rising edge of the synchronised pin while `supply_ok` is high captures the straps. `cfg_fsel` then holds `strap_fsel` (1 means 100 MHz, 0 means 133 MHz). `cfg_addr0` and `cfg_addr1` hold their straps, each coded 00 for low, 01 for mid and 10 for high. `cfg_valid` goes to 1 three edges after the pin rises.
- R9: Later pin edges leave the captured configuration unchanged until the next supply loss.
- R10: `out_en` is 1 exactly while `seq_state` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above its valid threshold |
| clk_valid | input | 1 | A valid input clock is present |
| pll_lock | input | 1 | Loop locked to the input clock |
| pgood_pdn_n | input | 1 | Dual-function pin, asynchronous: capture on the first rise, then active-low power-down |
| strap_fsel | input | 1 | Frequency select strap |
| strap_addr0 | input | 2 | Tri-level address strap 0 |
| strap_addr1 | input | 2 | Tri-level address strap 1 |
| seq_state | output | 2 | Current state number (0 to 3) |
| out_en | output | 1 | Clock outputs may drive |
| cfg_valid | output | 1 | Straps have been captured |
| cfg_fsel | output | 1 | Captured frequency select |
| cfg_addr0 | output | 2 | Captured address strap 0 |
| cfg_addr1 | output | 2 | Captured address strap 1 |

## Verification
The strap capture and the Qualify transition can both be triggered by the same synchronised pin edge. To provoke this, the bench holds the input clock and lock valid in Wait and then raises the pin for the first time. The check is that the captured fields appear on the edge where the pin is first seen high, and that Run follows exactly one edge later, never earlier. A second collision puts a pin release in Run on the same cycles as changed strap levels. The check there is that the pin release re-enters Run while the captured fields keep their first values.

// File: rtl/clkbuf_seq_pkg.sv
package clkbuf_seq_pkg;

    localparam int TRI_W = 2;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             fsel;
        logic [TRI_W-1:0] addr0;
        logic [TRI_W-1:0] addr1;
    } strap_cfg_t;

endpackage

// File: rtl/clkbuf_sync.sv
module clkbuf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkbuf_settle_timer.sv
module clkbuf_settle_timer #(
    parameter int DELAY_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Counts only while the settle state is active; restarts from zero on re-entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/clkbuf_strap_latch.sv
module clkbuf_strap_latch
    import clkbuf_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pin_s,
    input  strap_cfg_t straps,
    output logic       cfg_valid,
    output strap_cfg_t cfg
);
    logic pin_d;
    logic first_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin_s;
    end

    assign first_rise = supply_ok && pin_s && !pin_d && !cfg_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            cfg       <= '0;
        end else if (!supply_ok) begin
            cfg_valid <= 1'b0;
            cfg       <= '0;
        end else if (first_rise) begin
            cfg_valid <= 1'b1;
            cfg       <= straps;
        end
    end
endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
    import clkbuf_seq_pkg::*;
#(
    parameter int DELAY_CYCLES = 25000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             clk_valid,
    input  logic             pll_lock,
    input  logic             pgood_pdn_n,
    input  logic             strap_fsel,
    input  logic [TRI_W-1:0] strap_addr0,
    input  logic [TRI_W-1:0] strap_addr1,
    output logic [1:0]       seq_state,
    output logic             out_en,
    output logic             cfg_valid,
    output logic             cfg_fsel,
    output logic [TRI_W-1:0] cfg_addr0,
    output logic [TRI_W-1:0] cfg_addr1
);
    seq_state_e state_q, state_d;
    logic       pin_s;
    logic       settle_done;
    logic       qualified;
    strap_cfg_t straps, cfg;

    clkbuf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pgood_pdn_n),
        .q     (pin_s)
    );

    clkbuf_settle_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    assign straps = '{fsel: strap_fsel, addr0: strap_addr0, addr1: strap_addr1};

    clkbuf_strap_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pin_s     (pin_s),
        .straps    (straps),
        .cfg_valid (cfg_valid),
        .cfg       (cfg)
    );

    assign qualified = clk_valid && pll_lock && pin_s && cfg_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_SETTLE;
                ST_SETTLE: if (settle_done) state_d = ST_WAIT;
                ST_WAIT:   if (qualified)   state_d = ST_RUN;
                ST_RUN:    if (!qualified)  state_d = ST_WAIT;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        seq_state = state_q;
        out_en    = (state_q == ST_RUN);
        cfg_fsel  = cfg.fsel;
        cfg_addr0 = cfg.addr0;
        cfg_addr1 = cfg.addr1;
    end
endmodule

module clkbuf_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       clk_valid,
    input logic       pll_lock,
    input logic [1:0] seq_state,
    input logic       out_en,
    input logic       cfg_valid,
    input logic       cfg_fsel,
    input logic [1:0] cfg_addr0,
    input logic [1:0] cfg_addr1
);
    p_supply_loss_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (seq_state == 2'd0) && !out_en && !cfg_valid);

    p_settle_from_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd1) && ($past(seq_state) != 2'd1) |-> $past(seq_state) == 2'd0);

    p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> ($past(seq_state) == 2'd2) && $past(clk_valid)
                          && $past(pll_lock) && $past(cfg_valid));

    p_no_clock_no_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_valid |=> !out_en);

    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && $past(cfg_valid) |-> $stable(cfg_fsel) && $stable(cfg_addr0)
                                          && $stable(cfg_addr1));

    p_lock_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en && !pll_lock |=> !out_en);
endmodule

bind clkbuf_pwrup_seq clkbuf_pwrup_seq_chk u_chk (.*);

// File: tb/clkbuf_pwrup_seq_test.sv
module clkbuf_pwrup_seq_test;
    localparam int DLY = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, clk_valid = 1'b0, pll_lock = 1'b0, pgood_pdn_n = 1'b0;
    logic strap_fsel = 1'b0;
    logic [1:0] strap_addr0 = 2'd0, strap_addr1 = 2'd0;
    logic [1:0] seq_state, cfg_addr0, cfg_addr1;
    logic out_en, cfg_valid, cfg_fsel;

    always #2 clk = ~clk;

    clkbuf_pwrup_seq #(.DELAY_CYCLES(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clk_valid(clk_valid),
        .pll_lock(pll_lock), .pgood_pdn_n(pgood_pdn_n), .strap_fsel(strap_fsel),
        .strap_addr0(strap_addr0), .strap_addr1(strap_addr1), .seq_state(seq_state),
        .out_en(out_en), .cfg_valid(cfg_valid), .cfg_fsel(cfg_fsel),
        .cfg_addr0(cfg_addr0), .cfg_addr1(cfg_addr1)
    );

    typedef struct {
        int         cyc;
        bit         is_cfg;
        logic [1:0] st;
        logic       en;
        logic       v;
        logic       f;
        logic [1:0] a0;
        logic [1:0] a1;
        string      tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Monitor: pops every item due at this sample point and compares.
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (!it.is_cfg) begin
                if (seq_state !== it.st || out_en !== it.en) begin
                    errors++;
                    $display("FAIL %s: state=%0d en=%0b expected state=%0d en=%0b",
                             it.tag, seq_state, out_en, it.st, it.en);
                end
            end else begin
                if (cfg_valid !== it.v || cfg_fsel !== it.f ||
                    cfg_addr0 !== it.a0 || cfg_addr1 !== it.a1) begin
                    errors++;
                    $display("FAIL %s: cfg v=%0b f=%0b a0=%0d a1=%0d expected v=%0b f=%0b a0=%0d a1=%0d",
                             it.tag, cfg_valid, cfg_fsel, cfg_addr0, cfg_addr1,
                             it.v, it.f, it.a0, it.a1);
                end
            end
        end
    end

    task automatic exp_st(input int n, input logic [1:0] st, input logic en, input string tag);
        item_t it;
        it = '{cyc: cyc + n, is_cfg: 1'b0, st: st, en: en, v: 1'b0, f: 1'b0,
               a0: 2'd0, a1: 2'd0, tag: tag};
        q.push_back(it);
    endtask

    task automatic exp_cfg(input int n, input logic v, input logic f,
                           input logic [1:0] a0, input logic [1:0] a1, input string tag);
        item_t it;
        it = '{cyc: cyc + n, is_cfg: 1'b1, st: 2'd0, en: 1'b0, v: v, f: f,
               a0: a0, a1: a1, tag: tag};
        q.push_back(it);
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        exp_st(1, 2'd0, 1'b0, "R1 reset state");
        exp_cfg(1, 1'b0, 1'b0, 2'd0, 2'd0, "R1 reset cfg");
        step(2);

        // R2/R3: power-on and settle window
        strap_fsel = 1'b1; strap_addr0 = 2'd2; strap_addr1 = 2'd1;
        supply_ok = 1'b1;
        exp_st(1, 2'd1, 1'b0, "R2 off to settle");
        exp_st(DLY, 2'd1, 1'b0, "R3 still settling");
        exp_st(DLY + 1, 2'd2, 1'b0, "R3 settle done");
        step(DLY + 1);

        // R5/R8: pin and lock present, no input clock
        pll_lock = 1'b1; pgood_pdn_n = 1'b1;
        exp_st(3, 2'd2, 1'b0, "R5 no clock at capture");
        exp_cfg(3, 1'b1, 1'b1, 2'd2, 2'd1, "R8 first rise capture");
        exp_st(10, 2'd2, 1'b0, "R5 no clock held");
        step(10);

        // R4: clock arrives; straps change and must be ignored later
        strap_fsel = 1'b0; strap_addr0 = 2'd0; strap_addr1 = 2'd2;
        clk_valid = 1'b1;
        exp_st(1, 2'd3, 1'b1, "R4 qualify");
        step(2);

        // R6: clock loss and return
        clk_valid = 1'b0;
        exp_st(1, 2'd2, 1'b0, "R6 clock loss");
        step(1);
        clk_valid = 1'b1;
        exp_st(1, 2'd3, 1'b1, "R4 requalify");
        step(2);

        // R6: lock loss and return
        pll_lock = 1'b0;
        exp_st(1, 2'd2, 1'b0, "R6 lock loss");
        step(1);
        pll_lock = 1'b1;
        exp_st(1, 2'd3, 1'b1, "R10 run enables");
        step(2);

        // R6/R9: power-down through the pin, then release
        pgood_pdn_n = 1'b0;
        exp_st(2, 2'd3, 1'b1, "R6 pin sync delay");
        exp_st(3, 2'd2, 1'b0, "R6 pin power-down");
        step(4);
        pgood_pdn_n = 1'b1;
        exp_st(2, 2'd2, 1'b0, "R6 release sync delay");
        exp_st(3, 2'd3, 1'b1, "R6 release");
        exp_cfg(4, 1'b1, 1'b1, 2'd2, 2'd1, "R9 later edge ignored");
        step(5);

        // R7: supply loss from run
        supply_ok = 1'b0;
        exp_st(1, 2'd0, 1'b0, "R7 supply loss from run");
        exp_cfg(1, 1'b0, 1'b0, 2'd0, 2'd0, "R7 cfg cleared");
        step(2);

        // Same-cycle: first pin rise with clock and lock already valid
        pgood_pdn_n = 1'b0;
        step(3);
        strap_fsel = 1'b0; strap_addr0 = 2'd1; strap_addr1 = 2'd0;
        supply_ok = 1'b1;
        exp_st(DLY + 1, 2'd2, 1'b0, "R3 second power-up");
        step(DLY + 1);
        pgood_pdn_n = 1'b1;
        exp_st(3, 2'd2, 1'b0, "R4 waits for capture");
        exp_cfg(3, 1'b1, 1'b0, 2'd1, 2'd0, "R8 capture with clock present");
        exp_st(4, 2'd3, 1'b1, "R4 run after capture");
        step(6);

        // R7: supply loss in settle
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        exp_st(1, 2'd1, 1'b0, "R2 re-power");
        step(5);
        supply_ok = 1'b0;
        exp_st(1, 2'd0, 1'b0, "R7 supply loss from settle");
        step(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule